// File: doc/BRIEF.md
# Power-Management Control and System Control Interrupt Generator

This block holds the power-management control word, a small general-purpose event register file, and the logic that folds pending events into one system control interrupt (SCI) level. Firmware writes the control word as a whole 16-bit value. If the write carries the sleep-request bit, the block decodes the sleep type in the same write into a power-off request or a suspend request. The sleep-request bit itself is never kept in the register.

A separate 8-bit advanced power-management command port switches the SCI-enable bit of the control word on or off. It can also raise a system management interrupt (SMI) when that is configured. Event status and enable words of the fixed-event group come in as levels from neighbouring logic. The general-purpose event bytes sit behind a byte-wide register bus, and event sources set their status bits through one-cycle pulses. A resume input ends the suspended state. The block also gives a registered arm signal to an external timer counter.

Top module: `pm_sci_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, all event status and enable bytes read 0x00, and sci, tmr_arm, shutdown_req, suspend_req, suspended and smi are all low.
- R2: A control write stores the written 16-bit value with bit 13 (sleep request) forced to 0, and the stored value is visible on cnt_rdata in the next cycle.
- R3: A control write with bit 13 set and sleep type (bits 12:10) equal to 0 raises shutdown_req for exactly one cycle, in the cycle after the write.
- R4: A control write with bit 13 set and sleep type 1 raises suspend_req for one cycle after the write and sets suspended, which then stays high.
- R5: With bit 13 set, a sleep type equal to parameter S4_CODE (default 2) also raises shutdown_req for one cycle. Every other type, and any write with bit 13 clear, raises neither request.
- R6: A one-cycle pulse on resume clears suspended in the following cycle.
- R7: A command byte of 0xF1 on the command port sets control bit 0 (SCI enable), and 0xF0 clears it. Any other byte leaves the control word unchanged.
- R8: Every command-port write raises smi for exactly one cycle after the write when smi_cfg_en is high, and never when it is low.
- R9: Register bus byte addresses 0 and 1 are event status and addresses 2 and 3 are event enable. Status bits are cleared by writing 1 and are set by gpe_set pulses. A set pulse wins over a clear of the same bit in the same cycle. Enable bytes are plain read/write, and reads are combinational on gpe_addr.
- R10: sci goes high when pm1_sts AND pm1_en is nonzero in bits 0 (timer), 5 (global lock), 8 (power button) or 10 (real-time clock). Other fixed-event bits have no effect on sci.
- R11: sci also goes high when status byte 0 AND enable byte 0 is nonzero in bits 1 or 2. All other status bits, including all of byte 1, have no effect on sci.
- R12: sci is a register. It follows its sources one clock after they change, so it changes two cycles after a register-bus write or set pulse.
- R13: tmr_arm is registered high exactly when pm1_en bit 0 was set and pm1_sts bit 0 was clear in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm1_sts | input | 16 | Fixed-event status levels |
| pm1_en | input | 16 | Fixed-event enable levels |
| cnt_wr | input | 1 | Control word write strobe (16-bit access) |
| cnt_wdata | input | 16 | Control word write data |
| cnt_rdata | output | 16 | Stored control word |
| apm_wr | input | 1 | Command port write strobe |
| apm_data | input | 8 | Command port byte |
| smi_cfg_en | input | 1 | Allows command writes to raise smi |
| resume | input | 1 | Ends the suspended state |
| gpe_set | input | GPE_BYTES/2*8 | Per-bit event status set pulses |
| gpe_wr | input | 1 | Event register write strobe |
| gpe_addr | input | $clog2(GPE_BYTES) | Event register byte address |
| gpe_wdata | input | 8 | Event register write byte |
| gpe_rdata | output | 8 | Event register read byte |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Timer overflow arm |
| shutdown_req | output | 1 | One-cycle power-off request |
| suspend_req | output | 1 | One-cycle suspend request |
| suspended | output | 1 | Suspended flag |
| smi | output | 1 | One-cycle system management interrupt |

## Verification
Control-word contents, both sleep requests, the suspended flag and smi are due one cycle after the strobe that causes them. sci and tmr_arm are due one cycle after a change on the fixed-event inputs. After a register-bus write or a set pulse, sci is due two cycles later, because the event bytes are registered before the combining register. Register reads are combinational and are sampled in the cycle after the address is applied. Each expected item goes into the scoreboard stamped with the exact cycle in which it is due. The monitor compares it only on the falling edge of that cycle, so the cycle before the change is checked as well (for example sci still low one cycle after a set pulse).

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
  localparam int unsigned CTL_W        = 16;
  localparam int unsigned SLP_REQ_POS  = 13;
  localparam int unsigned SLP_TYP_POS  = 10;
  localparam int unsigned SLP_TYP_W    = 3;
  localparam int unsigned SCI_EN_POS   = 0;
  localparam int unsigned TMR_POS      = 0;
  // timer, global lock, power button, real-time clock
  localparam logic [CTL_W-1:0] FIX_SCI_MASK = 16'h0521;
  localparam logic [7:0]       GPE_SCI_MASK = 8'h06;
  localparam logic [7:0]       CMD_SCI_ON   = 8'hF1;
  localparam logic [7:0]       CMD_SCI_OFF  = 8'hF0;

  typedef enum logic [1:0] {
    SLP_NONE,
    SLP_POWER_OFF,
    SLP_SUSPEND
  } slp_act_e;
endpackage

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import pm_sci_pkg::*;
#(
  parameter int unsigned S4_CODE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CTL_W-1:0] cnt_wdata,
  input  logic             apm_wr,
  input  logic [7:0]       apm_data,
  input  logic             smi_cfg_en,
  input  logic             resume,
  output logic [CTL_W-1:0] cnt_q,
  output logic             shutdown_req,
  output logic             suspend_req,
  output logic             suspended,
  output logic             smi
);
  localparam logic [SLP_TYP_W-1:0] S4_TYP = SLP_TYP_W'(S4_CODE);

  logic [SLP_TYP_W-1:0] slp_typ;
  slp_act_e             act;
  logic [CTL_W-1:0]     cnt_d;
  logic                 cnt_en;
  logic                 shut_d, susp_d, flag_d, smi_d;

  // sleep decode: only a write carrying the request bit acts
  always_comb begin
    slp_typ = cnt_wdata[SLP_TYP_POS +: SLP_TYP_W];
    act     = SLP_NONE;
    if (cnt_wr && cnt_wdata[SLP_REQ_POS]) begin
      if (slp_typ == '0)
        act = SLP_POWER_OFF;
      else if (slp_typ == SLP_TYP_W'(1))
        act = SLP_SUSPEND;
      else if (slp_typ == S4_TYP)
        act = SLP_POWER_OFF;
    end
  end

  always_comb begin
    cnt_en = cnt_wr | apm_wr;
    cnt_d  = cnt_q;
    if (cnt_wr) begin
      cnt_d              = cnt_wdata;
      cnt_d[SLP_REQ_POS] = 1'b0;
    end
    if (apm_wr && (apm_data == CMD_SCI_ON))
      cnt_d[SCI_EN_POS] = 1'b1;
    else if (apm_wr && (apm_data == CMD_SCI_OFF))
      cnt_d[SCI_EN_POS] = 1'b0;

    shut_d = (act == SLP_POWER_OFF);
    susp_d = (act == SLP_SUSPEND);
    flag_d = suspended;
    if (resume)
      flag_d = 1'b0;
    if (act == SLP_SUSPEND)
      flag_d = 1'b1;
    smi_d = apm_wr & smi_cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      shutdown_req <= 1'b0;
      suspend_req  <= 1'b0;
      suspended    <= 1'b0;
      smi          <= 1'b0;
    end else begin
      if (cnt_en)
        cnt_q <= cnt_d;
      shutdown_req <= shut_d;
      suspend_req  <= susp_d;
      suspended    <= flag_d;
      smi          <= smi_d;
    end
  end
endmodule

// File: rtl/pm_gpe_regs.sv
module pm_gpe_regs #(
  parameter int unsigned GPE_BYTES = 4,
  localparam int unsigned HALF     = GPE_BYTES / 2,
  localparam int unsigned AW       = $clog2(GPE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gpe_wr,
  input  logic [AW-1:0]   gpe_addr,
  input  logic [7:0]      gpe_wdata,
  input  logic [HALF*8-1:0] gpe_set,
  output logic [7:0]      gpe_rdata,
  output logic [7:0]      sts0,
  output logic [7:0]      en0
);
  logic [HALF-1:0][7:0] sts_q, sts_d, en_q, en_d;
  logic [HALF-1:0]      en_we;

  always_comb begin
    for (int b = 0; b < HALF; b++) begin
      sts_d[b] = sts_q[b];
      if (gpe_wr && (gpe_addr == AW'(b)))
        sts_d[b] = sts_q[b] & ~gpe_wdata;
      sts_d[b] = sts_d[b] | gpe_set[b*8 +: 8];
      en_we[b] = gpe_wr && (gpe_addr == AW'(b + HALF));
      en_d[b]  = gpe_wdata;
    end
  end

  always_comb begin
    gpe_rdata = 8'h00;
    for (int b = 0; b < HALF; b++) begin
      if (gpe_addr == AW'(b))
        gpe_rdata = sts_q[b];
      if (gpe_addr == AW'(b + HALF))
        gpe_rdata = en_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      for (int b = 0; b < HALF; b++) begin
        if (en_we[b])
          en_q[b] <= en_d[b];
      end
    end
  end

  assign sts0 = sts_q[0];
  assign en0  = en_q[0];
endmodule

// File: rtl/pm_sci_combine.sv
module pm_sci_combine
  import pm_sci_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] pm1_sts,
  input  logic [CTL_W-1:0] pm1_en,
  input  logic [7:0]       gpe_sts0,
  input  logic [7:0]       gpe_en0,
  output logic             sci,
  output logic             tmr_arm
);
  logic fix_hit, gpe_hit, sci_d, arm_d;

  always_comb begin
    fix_hit = |(pm1_sts & pm1_en & FIX_SCI_MASK);
    gpe_hit = |(gpe_sts0 & gpe_en0 & GPE_SCI_MASK);
    sci_d   = fix_hit | gpe_hit;
    arm_d   = pm1_en[TMR_POS] & ~pm1_sts[TMR_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci     <= 1'b0;
      tmr_arm <= 1'b0;
    end else begin
      sci     <= sci_d;
      tmr_arm <= arm_d;
    end
  end
endmodule

// File: rtl/pm_sci_ctrl.sv
module pm_sci_ctrl #(
  parameter int unsigned S4_CODE   = 2,
  parameter int unsigned GPE_BYTES = 4,
  localparam int unsigned GPE_AW    = $clog2(GPE_BYTES),
  localparam int unsigned GPE_SET_W = GPE_BYTES / 2 * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          pm1_sts,
  input  logic [15:0]          pm1_en,
  input  logic                 cnt_wr,
  input  logic [15:0]          cnt_wdata,
  output logic [15:0]          cnt_rdata,
  input  logic                 apm_wr,
  input  logic [7:0]           apm_data,
  input  logic                 smi_cfg_en,
  input  logic                 resume,
  input  logic [GPE_SET_W-1:0] gpe_set,
  input  logic                 gpe_wr,
  input  logic [GPE_AW-1:0]    gpe_addr,
  input  logic [7:0]           gpe_wdata,
  output logic [7:0]           gpe_rdata,
  output logic                 sci,
  output logic                 tmr_arm,
  output logic                 shutdown_req,
  output logic                 suspend_req,
  output logic                 suspended,
  output logic                 smi
);
  logic [7:0] gpe_sts0;
  logic [7:0] gpe_en0;

  pm_ctl_reg #(.S4_CODE(S4_CODE)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (cnt_wdata),
    .apm_wr       (apm_wr),
    .apm_data     (apm_data),
    .smi_cfg_en   (smi_cfg_en),
    .resume       (resume),
    .cnt_q        (cnt_rdata),
    .shutdown_req (shutdown_req),
    .suspend_req  (suspend_req),
    .suspended    (suspended),
    .smi          (smi)
  );

  pm_gpe_regs #(.GPE_BYTES(GPE_BYTES)) u_gpe (
    .clk       (clk),
    .rst_n     (rst_n),
    .gpe_wr    (gpe_wr),
    .gpe_addr  (gpe_addr),
    .gpe_wdata (gpe_wdata),
    .gpe_set   (gpe_set),
    .gpe_rdata (gpe_rdata),
    .sts0      (gpe_sts0),
    .en0       (gpe_en0)
  );

  pm_sci_combine u_sci (
    .clk      (clk),
    .rst_n    (rst_n),
    .pm1_sts  (pm1_sts),
    .pm1_en   (pm1_en),
    .gpe_sts0 (gpe_sts0),
    .gpe_en0  (gpe_en0),
    .sci      (sci),
    .tmr_arm  (tmr_arm)
  );
endmodule

// File: rtl/pm_sci_ctrl_chk.sv
module pm_sci_ctrl_chk
  import pm_sci_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] pm1_sts,
  input logic [15:0] pm1_en,
  input logic        cnt_wr,
  input logic [15:0] cnt_wdata,
  input logic [15:0] cnt_rdata,
  input logic        apm_wr,
  input logic [7:0]  apm_data,
  input logic        smi_cfg_en,
  input logic        resume,
  input logic [7:0]  set0,
  input logic [7:0]  gpe_sts0,
  input logic [7:0]  gpe_en0,
  input logic        sci,
  input logic        tmr_arm,
  input logic        shutdown_req,
  input logic        suspend_req,
  input logic        suspended,
  input logic        smi
);
  a_r2_req_bit_never_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rdata[SLP_REQ_POS]);

  a_r3_off_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(cnt_wr && cnt_wdata[SLP_REQ_POS]));

  a_r4_suspend_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> suspended);

  a_r5_one_request_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && suspend_req));

  a_r6_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (!suspended || suspend_req));

  a_r7_cmd_on_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && (apm_data == CMD_SCI_ON)) |=> cnt_rdata[SCI_EN_POS]);

  a_r8_smi_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(apm_wr && smi_cfg_en));

  a_r9_set_pulse_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set0) |=> ((gpe_sts0 & $past(set0)) == $past(set0)));

  a_r12_sci_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> $past((|(pm1_sts & pm1_en & FIX_SCI_MASK)) ||
                         (|(gpe_sts0 & gpe_en0 & GPE_SCI_MASK))));

  a_r13_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_arm |-> $past(pm1_en[TMR_POS] && !pm1_sts[TMR_POS]));
endmodule

bind pm_sci_ctrl pm_sci_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pm1_sts      (pm1_sts),
  .pm1_en       (pm1_en),
  .cnt_wr       (cnt_wr),
  .cnt_wdata    (cnt_wdata),
  .cnt_rdata    (cnt_rdata),
  .apm_wr       (apm_wr),
  .apm_data     (apm_data),
  .smi_cfg_en   (smi_cfg_en),
  .resume       (resume),
  .set0         (gpe_set[7:0]),
  .gpe_sts0     (gpe_sts0),
  .gpe_en0      (gpe_en0),
  .sci          (sci),
  .tmr_arm      (tmr_arm),
  .shutdown_req (shutdown_req),
  .suspend_req  (suspend_req),
  .suspended    (suspended),
  .smi          (smi)
);

// File: tb/pm_sci_ctrl_tb.sv
module pm_sci_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef enum int {K_SCI, K_ARM, K_SHUT, K_SUSP, K_FLAG, K_SMI, K_CNT, K_GPE} kind_e;
  typedef struct {
    int    cyc;
    kind_e kind;
    int    val;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pm1_sts, pm1_en, cnt_wdata, cnt_rdata;
  logic        cnt_wr, apm_wr, smi_cfg_en, resume, gpe_wr;
  logic [7:0]  apm_data, gpe_wdata, gpe_rdata;
  logic [15:0] gpe_set;
  logic [1:0]  gpe_addr;
  logic        sci, tmr_arm, shutdown_req, suspend_req, suspended, smi;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pm_sci_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pm1_sts(pm1_sts), .pm1_en(pm1_en),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .apm_wr(apm_wr), .apm_data(apm_data), .smi_cfg_en(smi_cfg_en),
    .resume(resume), .gpe_set(gpe_set), .gpe_wr(gpe_wr), .gpe_addr(gpe_addr),
    .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata), .sci(sci), .tmr_arm(tmr_arm),
    .shutdown_req(shutdown_req), .suspend_req(suspend_req),
    .suspended(suspended), .smi(smi)
  );

  function automatic int observe(kind_e k);
    case (k)
      K_SCI:   return int'(sci);
      K_ARM:   return int'(tmr_arm);
      K_SHUT:  return int'(shutdown_req);
      K_SUSP:  return int'(suspend_req);
      K_FLAG:  return int'(suspended);
      K_SMI:   return int'(smi);
      K_CNT:   return int'(cnt_rdata);
      default: return int'(gpe_rdata);
    endcase
  endfunction

  // monitor: compare every item on the falling edge of its due cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      exp_t e;
      int   act;
      e = sb_q.pop_front();
      act = observe(e.kind);
      checks++;
      if (e.cyc < cyc) begin
        failures++;
        $display("FAIL %s item %s missed due=%0d now=%0d actual=%0h expected=%0h",
                 e.tag, e.kind.name(), e.cyc, cyc, act, e.val);
      end else if (act != e.val) begin
        failures++;
        $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h",
                 e.tag, e.kind.name(), cyc, act, e.val);
      end
    end
  end

  task automatic expect_at(int dly, kind_e k, int v, string tag);
    sb_q.push_back('{cyc + dly, k, v, tag});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cnt_write(logic [15:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
    idle(3);
  endtask

  task automatic cmd_write(logic [7:0] v, logic smi_en);
    apm_wr = 1'b1; apm_data = v; smi_cfg_en = smi_en;
    @(negedge clk);
    apm_wr = 1'b0;
    idle(3);
  endtask

  task automatic pulse_resume();
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    idle(3);
  endtask

  task automatic set_fixed(logic [15:0] s, logic [15:0] e);
    pm1_sts = s; pm1_en = e;
    @(negedge clk);
    idle(2);
  endtask

  task automatic gpe_drive(logic wr, logic [1:0] a, logic [7:0] d, logic [15:0] set);
    gpe_wr = wr; gpe_addr = a; gpe_wdata = d; gpe_set = set;
    @(negedge clk);
    gpe_wr = 1'b0; gpe_set = '0;
    idle(3);
  endtask

  task automatic gpe_read(logic [1:0] a, int v, string tag);
    gpe_addr = a;
    expect_at(1, K_GPE, v, tag);
    @(negedge clk);
    idle(1);
  endtask

  initial begin
    rst_n = 1'b0; pm1_sts = '0; pm1_en = '0; cnt_wr = 1'b0; cnt_wdata = '0;
    apm_wr = 1'b0; apm_data = '0; smi_cfg_en = 1'b0; resume = 1'b0;
    gpe_set = '0; gpe_wr = 1'b0; gpe_addr = '0; gpe_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_at(1, K_CNT, 0, "R1");  expect_at(1, K_SCI, 0, "R1");
    expect_at(1, K_ARM, 0, "R1");  expect_at(1, K_SHUT, 0, "R1");
    expect_at(1, K_SUSP, 0, "R1"); expect_at(1, K_FLAG, 0, "R1");
    expect_at(1, K_SMI, 0, "R1");  expect_at(1, K_GPE, 0, "R1");
    idle(2);

    // R2 request bit dropped; R5 type 3 does nothing
    expect_at(1, K_CNT, 'h0C01, "R2");
    expect_at(1, K_SHUT, 0, "R5"); expect_at(1, K_SUSP, 0, "R5");
    cnt_write(16'h2C01);

    // R3 type 0 power-off pulse
    expect_at(1, K_SHUT, 1, "R3"); expect_at(1, K_CNT, 0, "R2");
    expect_at(2, K_SHUT, 0, "R3");
    cnt_write(16'h2000);

    // R4 suspend
    expect_at(1, K_SUSP, 1, "R4"); expect_at(1, K_FLAG, 1, "R4");
    expect_at(2, K_SUSP, 0, "R4"); expect_at(3, K_FLAG, 1, "R4");
    cnt_write(16'h2400);

    // R6 resume
    expect_at(1, K_FLAG, 0, "R6");
    pulse_resume();

    // R5 S4 code, request bit clear, type 7
    expect_at(1, K_SHUT, 1, "R5");
    cnt_write(16'h2800);
    expect_at(1, K_SHUT, 0, "R5"); expect_at(1, K_CNT, 'h0800, "R5");
    cnt_write(16'h0800);
    expect_at(1, K_SHUT, 0, "R5"); expect_at(1, K_SUSP, 0, "R5");
    expect_at(1, K_CNT, 'h1C00, "R5");
    cnt_write(16'h3C00);

    // R7 / R8 command port
    expect_at(1, K_CNT, 'h1C01, "R7"); expect_at(1, K_SMI, 0, "R8");
    cmd_write(8'hF1, 1'b0);
    expect_at(1, K_CNT, 'h1C01, "R7"); expect_at(1, K_SMI, 1, "R8");
    expect_at(2, K_SMI, 0, "R8");
    cmd_write(8'h55, 1'b1);
    expect_at(1, K_CNT, 'h1C00, "R7"); expect_at(1, K_SMI, 1, "R8");
    cmd_write(8'hF0, 1'b1);

    // R10 / R13 fixed events
    expect_at(1, K_SCI, 1, "R10"); expect_at(1, K_ARM, 0, "R13");
    set_fixed(16'h0100, 16'h0100);
    expect_at(1, K_SCI, 0, "R10");
    set_fixed(16'h0002, 16'h0002);
    expect_at(1, K_SCI, 1, "R10");
    set_fixed(16'h0400, 16'h0400);
    expect_at(1, K_SCI, 1, "R10");
    set_fixed(16'h0020, 16'h0020);
    expect_at(1, K_SCI, 0, "R10"); expect_at(1, K_ARM, 1, "R13");
    set_fixed(16'h0000, 16'h0001);
    expect_at(1, K_SCI, 1, "R10"); expect_at(1, K_ARM, 0, "R13");
    set_fixed(16'h0001, 16'h0001);
    expect_at(1, K_SCI, 0, "R10"); expect_at(1, K_ARM, 0, "R13");
    set_fixed(16'h0000, 16'h0000);

    // R9 / R11 / R12 event register file
    expect_at(2, K_SCI, 0, "R11");
    gpe_drive(1'b1, 2'd2, 8'h06, 16'h0000);
    gpe_read(2'd2, 'h06, "R9");
    expect_at(1, K_SCI, 0, "R12"); expect_at(2, K_SCI, 1, "R12");
    gpe_drive(1'b0, 2'd0, 8'h00, 16'h0002);
    gpe_read(2'd0, 'h02, "R9");
    expect_at(1, K_SCI, 1, "R12"); expect_at(2, K_SCI, 0, "R9");
    gpe_drive(1'b1, 2'd0, 8'h02, 16'h0000);
    gpe_read(2'd0, 'h00, "R9");
    gpe_drive(1'b1, 2'd2, 8'h0E, 16'h0000);
    expect_at(2, K_SCI, 0, "R11");
    gpe_drive(1'b0, 2'd0, 8'h00, 16'h0008);
    gpe_read(2'd0, 'h08, "R9");
    expect_at(2, K_SCI, 1, "R9");
    gpe_drive(1'b1, 2'd0, 8'h04, 16'h0004);
    gpe_read(2'd0, 'h0C, "R9");
    gpe_drive(1'b0, 2'd0, 8'h00, 16'h0200);
    gpe_read(2'd1, 'h02, "R9");
    gpe_drive(1'b1, 2'd3, 8'hFF, 16'h0000);
    gpe_read(2'd3, 'hFF, "R9");
    expect_at(2, K_SCI, 0, "R11");
    gpe_drive(1'b1, 2'd0, 8'hFF, 16'h0000);
    gpe_read(2'd1, 'h02, "R11");

    idle(4);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule